// File: doc/BRIEF.md
# Structural Hazard Reservation Gate

This block decides, one request at a time, whether an instruction class may start execution on a dual-pipe integer/float core without colliding with functional units already booked by earlier instructions. Each class books a fixed pattern of units across several future cycles. Some classes can choose between two pipes or two load/store ports. Some hold a unit for many cycles, such as the multiplier or the float divider. The gate keeps a per-unit occupancy map that looks 40 cycles ahead. It answers a request combinationally. On acceptance it books the chosen pattern at the next clock edge.

An issue stage presents `req_valid` with a class code. It reads `accept` or `reject` and `alt_used` in the same cycle, and it pulses `advance` when the machine moves to the next cycle. `deadlock` tells the stage that no class code can start until time advances. This happens either because both issue slots of the cycle are taken, or because nothing fits the occupancy map.

Top module: `hz_reservation_gate`

## Requirements
- R1: After synchronous reset, no unit is booked, `deadlock` is low and every defined class code is accepted.
- R2: A rejected request books nothing. Later answers are exactly those that would occur had the request never been made.
- R3: An accepted request books its whole pattern, including cycles far in the future. Any later request that overlaps any booked unit-cycle is rejected.
- R4: `advance` is always honoured. It moves every booking one cycle closer and ends the cycle's issue group, so that `deadlock` caused by full slots clears.
- R5: At most two requests are accepted between advances. After the second, `deadlock` is high and every request, NOP included, is rejected.
- R6: A load (code 1) is rejected in the same cycle as a store (code 2) and one advance after it. It is accepted two advances after it.
- R7: `alt_used` bit 0 set means the secondary pipe (e1, or the float multiply pipe) was chosen. Bit 1 set means load/store port 2 was chosen. The order of preference is e0/port1, e1/port1, e0/port2, e1/port2. `alt_used` is 0 whenever `accept` is low.
- R8: A 32-bit multiply (code 7) holds the multiplier for 4 cycles and its write-back slot again 6 cycles after issue. A 64-bit multiply (code 8) holds the multiplier for 8 cycles. A high multiply (code 9) books write-back 12 cycles after issue. An e0-only class (code 3) is rejected in a write-back cycle, while an either-pipe class (code 4) moves to e1.
- R9: A single divide (code 11) holds the divider for 18 cycles and books divider write-back in its last divider cycle. A double divide (code 12) holds the divider for 30 cycles.
- R10: Branches (code 5) use e1 only. Float branches (code 6) use the float add pipe only. Float multiplies (code 13) use the float multiply pipe only. A float copy (code 14) uses the add pipe or, failing that, the multiply pipe.
- R11: NOP (code 0) books nothing and is accepted whenever an issue slot is free. Code 15 is undefined and always rejected.
- R12: `deadlock` is high exactly when no class code would be accepted in the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Issue request present |
| req_class | input | 4 | Instruction class code |
| advance | input | 1 | Move to the next machine cycle at this edge |
| accept | output | 1 | Request may start; its pattern is booked |
| reject | output | 1 | Request conflicts; nothing changes |
| alt_used | output | 2 | Alternative chosen on accept |
| deadlock | output | 1 | No class can start before an advance |

## Verification
A table of mixed loads, stores, branches and float copies checks three things. It separates port conflicts from store-reservation conflicts, and it separates first-choice from fallback alternatives. It also checks the slot-limit deadlock. Directed multiply and divide runs step time across long holds. They probe the exact cycle where the multiplier, the write-back slot or the divider frees up, which shows whether off-by-one bookings occur. Rejections of long-hold classes are followed by requests that would only fail if the rejected pattern had been booked, which isolates R2. A reset in the middle of a long hold shows that bookings are cleared.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int HORIZON = 40;
    localparam int N_UNITS = 11;
    localparam int N_ALTS  = 4;
    localparam int ALT_W   = 2;
    localparam int N_CODES = 16;

    // unit lane indices
    localparam int U_E0   = 0;
    localparam int U_E1   = 1;
    localparam int U_LS1  = 2;
    localparam int U_LS2  = 3;
    localparam int U_STR  = 4;
    localparam int U_MWB  = 5;
    localparam int U_MUL  = 6;
    localparam int U_FA   = 7;
    localparam int U_FM   = 8;
    localparam int U_FDIV = 9;
    localparam int U_DWB  = 10;

    typedef enum logic [3:0] {
        C_NOP   = 4'd0,
        C_LOAD  = 4'd1,
        C_STORE = 4'd2,
        C_IADD  = 4'd3,
        C_ILOG  = 4'd4,
        C_BR    = 4'd5,
        C_FBR   = 4'd6,
        C_MUL32 = 4'd7,
        C_MUL64 = 4'd8,
        C_MULHI = 4'd9,
        C_FADD  = 4'd10,
        C_DIVS  = 4'd11,
        C_DIVD  = 4'd12,
        C_FMUL  = 4'd13,
        C_FCPY  = 4'd14,
        C_BAD   = 4'd15
    } cls_e;

    typedef logic [HORIZON-1:0] lane_t;
    typedef lane_t [N_UNITS-1:0] occ_t;

    typedef struct packed {
        logic             fit;
        logic [ALT_W-1:0] alt;
    } choice_t;

    function automatic lane_t span(input int first, input int len);
        lane_t r;
        for (int i = 0; i < HORIZON; i++)
            r[i] = (i >= first) && (i < first + len);
        return r;
    endfunction

    function automatic int alt_count(input cls_e c);
        case (c)
            C_LOAD:         return 4;
            C_ILOG, C_FCPY: return 2;
            C_BAD:          return 0;
            default:        return 1;
        endcase
    endfunction

    // alt[0]: secondary pipe, alt[1]: second load/store port
    function automatic occ_t class_pattern(input cls_e c, input logic [ALT_W-1:0] alt);
        occ_t p;
        p = '0;
        case (c)
            C_LOAD: begin
                if (alt[0]) p[U_E1] = span(0, 1);
                else begin
                    p[U_E0]  = span(0, 1);
                    p[U_MWB] = span(0, 1);
                end
                if (alt[1]) p[U_LS2] = span(0, 1);
                else        p[U_LS1] = span(0, 1);
                p[U_STR] = span(0, 1);
            end
            C_STORE: begin
                p[U_E0]  = span(0, 1);
                p[U_MWB] = span(0, 1);
                p[U_LS1] = span(0, 1);
                p[U_LS2] = span(0, 1);
                p[U_STR] = span(1, 1);
            end
            C_IADD: begin
                p[U_E0]  = span(0, 1);
                p[U_MWB] = span(0, 1);
            end
            C_ILOG: begin
                if (alt[0]) p[U_E1] = span(0, 1);
                else begin
                    p[U_E0]  = span(0, 1);
                    p[U_MWB] = span(0, 1);
                end
            end
            C_BR:  p[U_E1] = span(0, 1);
            C_FBR: p[U_FA] = span(0, 1);
            C_MUL32, C_MUL64, C_MULHI: begin
                p[U_E0] = span(0, 1);
                if (c == C_MUL32) begin
                    p[U_MUL] = span(0, 4);
                    p[U_MWB] = span(0, 1) | span(6, 1);
                end else if (c == C_MUL64) begin
                    p[U_MUL] = span(0, 8);
                    p[U_MWB] = span(0, 1) | span(10, 1);
                end else begin
                    p[U_MUL] = span(0, 8);
                    p[U_MWB] = span(0, 1) | span(12, 1);
                end
            end
            C_FADD: begin
                p[U_FA]  = span(0, 1);
                p[U_DWB] = span(0, 1);
            end
            C_DIVS: begin
                p[U_FA]   = span(0, 1);
                p[U_FDIV] = span(0, 18);
                p[U_DWB]  = span(17, 1);
            end
            C_DIVD: begin
                p[U_FA]   = span(0, 1);
                p[U_FDIV] = span(0, 30);
                p[U_DWB]  = span(29, 1);
            end
            C_FMUL: p[U_FM] = span(0, 1);
            C_FCPY: begin
                if (alt[0]) p[U_FM] = span(0, 1);
                else begin
                    p[U_FA]  = span(0, 1);
                    p[U_DWB] = span(0, 1);
                end
            end
            default: p = '0;
        endcase
        return p;
    endfunction

    function automatic logic collides(input occ_t a, input occ_t b);
        return |(a & b);
    endfunction

    function automatic choice_t pick(input occ_t occ, input cls_e c);
        choice_t ch;
        ch = '0;
        for (int a = 0; a < N_ALTS; a++) begin
            if (!ch.fit && a < alt_count(c) &&
                !collides(occ, class_pattern(c, ALT_W'(a)))) begin
                ch.fit = 1'b1;
                ch.alt = ALT_W'(a);
            end
        end
        return ch;
    endfunction

endpackage

// File: rtl/hz_class_eval.sv
module hz_class_eval
    import hz_pkg::*;
(
    input  occ_t             occ,
    input  cls_e             cls,
    output logic             fit,
    output logic [ALT_W-1:0] alt,
    output occ_t             pat
);
    choice_t ch;

    always_comb begin
        ch  = pick(occ, cls);
        fit = ch.fit;
        alt = ch.alt;
        pat = ch.fit ? class_pattern(cls, ch.alt) : '0;
    end
endmodule

// File: rtl/hz_occupancy.sv
module hz_occupancy
    import hz_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic merge,
    input  occ_t pat,
    input  logic advance,
    output occ_t occ
);
    occ_t nxt;

    always_comb begin
        nxt = occ | (merge ? pat : '0);
        if (advance) begin
            for (int u = 0; u < N_UNITS; u++)
                nxt[u] = nxt[u] >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else     occ <= nxt;
    end
endmodule

// File: rtl/hz_issue_slots.sv
module hz_issue_slots #(
    parameter int ISSUE_WIDTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic advance,
    output logic full
);
    localparam int CW = $clog2(ISSUE_WIDTH + 1);

    logic [CW-1:0] used;

    assign full = (used == CW'(ISSUE_WIDTH));

    always_ff @(posedge clk) begin
        if (rst)          used <= '0;
        else if (advance) used <= '0;
        else if (accept)  used <= used + 1'b1;
    end
endmodule

// File: rtl/hz_reservation_gate.sv
module hz_reservation_gate
    import hz_pkg::*;
#(
    parameter int ISSUE_WIDTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [3:0] req_class,
    input  logic       advance,
    output logic       accept,
    output logic       reject,
    output logic [1:0] alt_used,
    output logic       deadlock
);
    occ_t               occ_q;
    occ_t               req_pat;
    logic               req_fit;
    logic [ALT_W-1:0]   req_alt;
    logic               slots_full;
    logic [N_CODES-1:0] code_fit;

    hz_class_eval u_eval (
        .occ (occ_q),
        .cls (cls_e'(req_class)),
        .fit (req_fit),
        .alt (req_alt),
        .pat (req_pat)
    );

    hz_occupancy u_occ (
        .clk     (clk),
        .rst     (rst),
        .merge   (accept),
        .pat     (req_pat),
        .advance (advance),
        .occ     (occ_q)
    );

    hz_issue_slots #(.ISSUE_WIDTH(ISSUE_WIDTH)) u_slots (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .advance (advance),
        .full    (slots_full)
    );

    for (genvar g = 0; g < N_CODES; g++) begin : g_probe
        choice_t ch_g;
        assign ch_g        = pick(occ_q, cls_e'(4'(g)));
        assign code_fit[g] = ch_g.fit;
    end

    assign accept   = req_valid && req_fit && !slots_full;
    assign reject   = req_valid && !accept;
    assign alt_used = accept ? req_alt : '0;
    assign deadlock = slots_full || !(|code_fit);
endmodule

// File: rtl/hz_gate_checker.sv
module hz_gate_checker
    import hz_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [3:0] req_class,
    input logic       advance,
    input logic       accept,
    input logic       reject,
    input logic [1:0] alt_used,
    input logic       deadlock,
    input occ_t       occ
);
    // R1: reset empties the booking map and clears deadlock
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (occ == '0) && !deadlock);

    // R2: a rejected request (no advance) leaves the bookings as they were
    a_r2_reject_holds: assert property (@(posedge clk) disable iff (rst)
        (reject && !advance) |=> (occ == $past(occ)));

    // R3: a valid request is answered by exactly one of accept or reject
    a_r3_one_answer: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (accept != reject));

    // R4: an advance without a booking brings every lane one step closer
    a_r4_shift_step: assert property (@(posedge clk) disable iff (rst)
        (advance && !accept) |=> (occ[U_FDIV][HORIZON-2:0] == $past(occ[U_FDIV][HORIZON-1:1])));

    // R5: nothing is accepted while deadlock is reported
    a_r5_no_accept_dead: assert property (@(posedge clk) disable iff (rst)
        deadlock |-> !accept);

    // R7: alternative output is zero unless accepted
    a_r7_alt_quiet: assert property (@(posedge clk) disable iff (rst)
        !accept |-> (alt_used == 2'b00));

    // R11: undefined code never accepted
    a_r11_bad_code: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_class == 4'd15) |-> reject);

    // R12: without deadlock a NOP always gets through
    a_r12_nop_flows: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_class == 4'd0 && !deadlock) |-> accept);
endmodule

bind hz_reservation_gate hz_gate_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_class (req_class),
    .advance   (advance),
    .accept    (accept),
    .reject    (reject),
    .alt_used  (alt_used),
    .deadlock  (deadlock),
    .occ       (occ_q)
);

// File: tb/sim_hz_reservation_gate.sv
module sim_hz_reservation_gate;
    import hz_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic [3:0] req;   // requirement number for reporting
        logic       adv;
        logic       vld;
        logic [3:0] cls;
        logic       acc;
        logic [1:0] alt;
        logic       dead;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'd7,  1'b0, 1'b1, 4'd1,  1'b1, 2'd0, 1'b0}, // R7 load first choice
        '{4'd3,  1'b1, 1'b1, 4'd1,  1'b0, 2'd0, 1'b0}, // R3 second load clashes on store slot
        '{4'd6,  1'b0, 1'b1, 4'd2,  1'b1, 2'd0, 1'b0}, // R6 store
        '{4'd6,  1'b1, 1'b1, 4'd1,  1'b0, 2'd0, 1'b0}, // R6 load with store
        '{4'd6,  1'b1, 1'b1, 4'd1,  1'b0, 2'd0, 1'b0}, // R6 load one cycle later
        '{4'd6,  1'b0, 1'b1, 4'd1,  1'b1, 2'd0, 1'b0}, // R6 load two cycles later
        '{4'd7,  1'b0, 1'b1, 4'd4,  1'b1, 2'd1, 1'b0}, // R7 logic falls back to e1
        '{4'd5,  1'b1, 1'b1, 4'd0,  1'b0, 2'd0, 1'b1}, // R5 third issue blocked
        '{4'd10, 1'b0, 1'b1, 4'd5,  1'b1, 2'd0, 1'b0}, // R10 branch on e1
        '{4'd10, 1'b0, 1'b1, 4'd5,  1'b0, 2'd0, 1'b0}, // R10 second branch blocked
        '{4'd10, 1'b1, 1'b1, 4'd14, 1'b1, 2'd0, 1'b0}, // R10 copy on add pipe
        '{4'd10, 1'b0, 1'b1, 4'd10, 1'b1, 2'd0, 1'b0}, // R10 float add
        '{4'd10, 1'b1, 1'b1, 4'd14, 1'b1, 2'd1, 1'b0}, // R10 copy moves to multiply pipe
        '{4'd11, 1'b0, 1'b1, 4'd15, 1'b0, 2'd0, 1'b0}, // R11 undefined code
        '{4'd4,  1'b1, 1'b0, 4'd0,  1'b0, 2'd0, 1'b0}  // R4 idle advance
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [3:0] req_class = 4'd0;
    logic       advance = 1'b0;
    logic       accept, reject, deadlock;
    logic [1:0] alt_used;

    int n_checks = 0;
    int n_fail   = 0;
    logic       s_acc, s_dead;
    logic [1:0] s_alt;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hz_reservation_gate u0 (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_class (req_class),
        .advance   (advance),
        .accept    (accept),
        .reject    (reject),
        .alt_used  (alt_used),
        .deadlock  (deadlock)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic a, input logic v, input logic [3:0] c);
        @(negedge clk);
        advance   = a;
        req_valid = v;
        req_class = c;
        #1;
        s_acc  = accept;
        s_alt  = alt_used;
        s_dead = deadlock;
        @(posedge clk);
        #1;
        advance   = 1'b0;
        req_valid = 1'b0;
    endtask

    task automatic expect3(input string tag, input logic ea, input logic [1:0] ealt, input logic ed);
        chk(s_acc == ea,   {tag, " accept"},   int'(s_acc),  int'(ea));
        chk(s_alt == ealt, {tag, " alt_used"}, int'(s_alt),  int'(ealt));
        chk(s_dead == ed,  {tag, " deadlock"}, int'(s_dead), int'(ed));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 4'd0);
    endtask

    initial begin : watchdog
        for (int cyc = 0; cyc < WATCHDOG; cyc++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        do_reset();
        #1;
        // R1: reset state
        chk(deadlock == 1'b0, "R1 deadlock after reset", int'(deadlock), 0);
        chk(accept == 1'b0,   "R1 no accept when idle",  int'(accept), 0);

        for (int k = 0; k < NV; k++) begin
            step(VECS[k].adv, VECS[k].vld, VECS[k].cls);
            expect3($sformatf("R%0d table vector %0d", VECS[k].req, k),
                    VECS[k].acc, VECS[k].alt, VECS[k].dead);
        end

        // R8: 32-bit multiply timing, with R2 rejection of 64-bit multiplies
        do_reset();
        step(1'b1, 1'b1, C_MUL32);  expect3("R8 mul32 issue", 1'b1, 2'd0, 1'b0);
        for (int k = 1; k <= 3; k++) begin
            step(1'b1, 1'b1, C_MUL64); expect3("R3 mul64 while multiplier busy", 1'b0, 2'd0, 1'b0);
        end
        idle(2);
        step(1'b0, 1'b1, C_IADD);  expect3("R8 e0 class in write-back cycle", 1'b0, 2'd0, 1'b0);
        step(1'b0, 1'b1, C_ILOG);  expect3("R8 logic moves to e1", 1'b1, 2'd1, 1'b0);
        step(1'b1, 1'b1, C_MUL32); expect3("R8 mul32 in write-back cycle", 1'b0, 2'd0, 1'b0);
        step(1'b1, 1'b1, C_MUL32); expect3("R2 mul32 after rejected mul64s", 1'b1, 2'd0, 1'b0);

        // R8: high multiply write-back 12 cycles later
        do_reset();
        step(1'b1, 1'b1, C_MULHI); expect3("R8 mulhi issue", 1'b1, 2'd0, 1'b0);
        idle(10);
        step(1'b1, 1'b1, C_IADD);  expect3("R8 e0 class before write-back", 1'b1, 2'd0, 1'b0);
        step(1'b0, 1'b1, C_IADD);  expect3("R8 e0 class at write-back", 1'b0, 2'd0, 1'b0);
        step(1'b1, 1'b1, C_ILOG);  expect3("R8 logic on e1 at write-back", 1'b1, 2'd1, 1'b0);

        // R9: divide holds
        do_reset();
        step(1'b1, 1'b1, C_DIVS);  expect3("R9 single divide issue", 1'b1, 2'd0, 1'b0);
        idle(16);
        step(1'b0, 1'b1, C_FADD);  expect3("R9 add blocked by divide write-back", 1'b0, 2'd0, 1'b0);
        step(1'b0, 1'b1, C_DIVD);  expect3("R9 divide while divider busy", 1'b0, 2'd0, 1'b0);
        step(1'b1, 1'b1, C_FBR);   expect3("R2 add pipe free after rejected divide", 1'b1, 2'd0, 1'b0);
        step(1'b1, 1'b1, C_DIVD);  expect3("R9 double divide when divider frees", 1'b1, 2'd0, 1'b0);
        idle(28);
        step(1'b1, 1'b1, C_DIVS);  expect3("R9 divide in last double cycle", 1'b0, 2'd0, 1'b0);
        step(1'b0, 1'b1, C_DIVS);  expect3("R9 divide after 30 cycles", 1'b1, 2'd0, 1'b0);

        // R5 / R4 / R12: slot deadlock and release
        step(1'b0, 1'b1, C_FMUL);  expect3("R5 second issue", 1'b1, 2'd0, 1'b0);
        step(1'b0, 1'b1, C_NOP);   expect3("R12 nop in full cycle", 1'b0, 2'd0, 1'b1);
        step(1'b1, 1'b0, C_NOP);   expect3("R4 advance from deadlock", 1'b0, 2'd0, 1'b1);
        step(1'b0, 1'b1, C_NOP);   expect3("R11 nop after advance", 1'b1, 2'd0, 1'b0);

        // R1: reset during a long hold clears it
        step(1'b1, 1'b1, C_DIVD);  expect3("R3 divide blocked by earlier divide", 1'b0, 2'd0, 1'b0);
        do_reset();
        step(1'b0, 1'b1, C_DIVD);  expect3("R1 divide right after reset", 1'b1, 2'd0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule